// File: doc/BRIEF.md
# ADC Conversion Trigger Controller

This block decides the clock cycle in which an analog-to-digital conversion begins. A conversion can be requested by software, through a write strobe from the bus decode of a start register, or by an edge on an asynchronous external trigger pin. The external pin is first synchronised and then debounced by a level filter. The active edge is chosen by a polarity input. After a request is accepted, the block sends a one-cycle start pulse to the converter. It then holds a busy flag until the converter returns its done pulse, and refuses every other request while that flag is set.

With the external source selected, the block runs in one of two arming styles. In automatic style, every qualified edge starts a conversion. In primed style, software must arm the block with a start-register write before each edge-started conversion, and the arming is withdrawn once that conversion completes.

Top module: `adc_trig_ctrl`

## Requirements
- R1: With `src_sel`=0 (software source) and `busy` low, a cycle with `start_wr` high makes `conv_start` high for exactly one cycle, in the cycle right after the write. `busy` goes high in that same cycle.
- R2: `busy` stays high until a cycle with `conv_done` high, and it is low in the cycle after that. A `conv_done` pulse while `busy` is low has no effect.
- R3: While `busy` is high, no request from either source produces `conv_start`. This includes a request in the same cycle as `conv_done`.
- R4: With `src_sel`=1, `pol`=0 qualifies only rising edges of `async_in` and `pol`=1 qualifies only falling edges. The opposite edge never starts a conversion.
- R5: A level on `async_in` counts only after it has been sampled unchanged for `FILT_CYCLES` consecutive clocks behind a `SYNC_STAGES`-flop synchroniser. A shorter pulse is dropped. For an accepted edge, `conv_start` goes high `SYNC_STAGES`+`FILT_CYCLES`+1 clock edges after the new level is first applied before an edge.
- R6: With `src_sel`=1 and `auto_mode`=1, every qualified edge that arrives while idle starts a conversion. A `start_wr` in this mode neither starts a conversion nor sets `primed`.
- R7: With `src_sel`=1 and `auto_mode`=0, an idle `start_wr` sets `primed` in the next cycle and does not start a conversion. A qualified edge starts a conversion only while `primed` is high. `primed` is low in the cycle after the `conv_done` that ends that conversion, and later edges are then ignored.
- R8: In primed style, a `start_wr` that arrives while `busy` is high does not arm the block for the period after the conversion completes.
- R9: Reset holds `conv_start`, `busy` and `primed` low. If `async_in` sits at its idle level (the level opposite to the active edge) when reset is released, no conversion starts.
- R10: Outside primed style (`src_sel`=0 or `auto_mode`=1), `primed` is low from the next cycle on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous reset, active high |
| async_in | input | 1 | Asynchronous external trigger pin |
| start_wr | input | 1 | One-cycle strobe: start register written (data ignored) |
| src_sel | input | 1 | 0 = software source, 1 = external pin |
| pol | input | 1 | 0 = rising edge active, 1 = falling edge active |
| auto_mode | input | 1 | 1 = automatic style, 0 = primed style (external source) |
| conv_done | input | 1 | One-cycle pulse from the converter at end of conversion |
| conv_start | output | 1 | One-cycle conversion start pulse |
| busy | output | 1 | Conversion in progress |
| primed | output | 1 | Armed for the next external edge in primed style |

## Verification
The bench builds the block with `SYNC_STAGES`=2 and `FILT_CYCLES`=3. This is shorter than the default filter length, so a pulse one clock too short and a pulse of exactly the minimum length both fit in a few cycles, and the start cycle of every accepted edge can be predicted to the exact clock. With this filter length, edges, glitches, done pulses and software writes can also be interleaved closely enough to reach the busy lockout, the coincidence of a request with `conv_done`, and arming while busy.

// File: rtl/adc_trig_pkg.sv
package adc_trig_pkg;

  typedef enum logic {
    SRC_SOFT = 1'b0,
    SRC_EXT  = 1'b1
  } trigSrc_t;

  // Strobes handed from the datapath to the control
  typedef struct packed {
    logic extEdge;   // qualified edge of the filtered pin level
    logic swWrite;   // start-register write event
  } trigStrobes_t;

endpackage

// File: rtl/adc_trig_dp.sv
module adc_trig_dp
  import adc_trig_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int FILT_CYCLES = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         asyncIn,
  input  logic         startWr,
  input  logic         pol,
  output trigStrobes_t strobes
);

  localparam int CNT_W = (FILT_CYCLES < 2) ? 1 : $clog2(FILT_CYCLES + 1);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(FILT_CYCLES - 1);

  logic [SYNC_STAGES-1:0] syncReg;
  logic                   syncLvl;
  logic                   filtLvl;
  logic [CNT_W-1:0]       stableCnt;
  logic                   filtUpdate;
  logic                   riseQ;
  logic                   fallQ;

  // Synchroniser chain; reset loads the idle level so release is edge-free
  always_ff @(posedge clk) begin
    if (rst) begin
      syncReg <= {SYNC_STAGES{pol}};
    end else begin
      syncReg <= {syncReg[SYNC_STAGES-2:0], asyncIn};
    end
  end

  assign syncLvl = syncReg[SYNC_STAGES-1];

  // Level filter: the synchronised level must differ for FILT_CYCLES clocks
  assign filtUpdate = (syncLvl != filtLvl) && (stableCnt == CNT_LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      filtLvl   <= pol;
      stableCnt <= '0;
    end else if (syncLvl == filtLvl) begin
      stableCnt <= '0;
    end else if (filtUpdate) begin
      filtLvl   <= syncLvl;
      stableCnt <= '0;
    end else begin
      stableCnt <= stableCnt + 1'b1;
    end
  end

  // Edge strobes of the filtered level
  always_ff @(posedge clk) begin
    if (rst) begin
      riseQ <= 1'b0;
      fallQ <= 1'b0;
    end else begin
      riseQ <= filtUpdate &&  syncLvl;
      fallQ <= filtUpdate && !syncLvl;
    end
  end

  always_comb begin
    strobes.extEdge = pol ? fallQ : riseQ;
    strobes.swWrite = startWr;
  end

endmodule

// File: rtl/adc_trig_fsm.sv
module adc_trig_fsm
  import adc_trig_pkg::*;
(
  input  logic         clk,
  input  logic         rst,
  input  trigStrobes_t strobes,
  input  logic         srcSel,
  input  logic         autoMode,
  input  logic         convDone,
  output logic         convStart,
  output logic         busy,
  output logic         primed
);

  logic extSel;
  logic primeMode;
  logic accept;
  logic startQ;
  logic busyQ;
  logic primedQ;

  always_comb begin
    extSel    = (trigSrc_t'(srcSel) == SRC_EXT);
    primeMode = extSel && !autoMode;
    if (extSel) begin
      accept = !busyQ && strobes.extEdge && (autoMode || primedQ);
    end else begin
      accept = !busyQ && strobes.swWrite;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      startQ  <= 1'b0;
      busyQ   <= 1'b0;
      primedQ <= 1'b0;
    end else begin
      startQ <= accept;

      if (accept) begin
        busyQ <= 1'b1;
      end else if (convDone) begin
        busyQ <= 1'b0;
      end

      if (!primeMode) begin
        primedQ <= 1'b0;
      end else if (busyQ && convDone) begin
        primedQ <= 1'b0;
      end else if (strobes.swWrite && !busyQ) begin
        primedQ <= 1'b1;
      end
    end
  end

  assign convStart = startQ;
  assign busy      = busyQ;
  assign primed    = primedQ;

endmodule

// File: rtl/adc_trig_ctrl.sv
module adc_trig_ctrl
  import adc_trig_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int FILT_CYCLES = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic async_in,
  input  logic start_wr,
  input  logic src_sel,
  input  logic pol,
  input  logic auto_mode,
  input  logic conv_done,
  output logic conv_start,
  output logic busy,
  output logic primed
);

  trigStrobes_t strobes;

  adc_trig_dp #(
    .SYNC_STAGES(SYNC_STAGES),
    .FILT_CYCLES(FILT_CYCLES)
  ) u_dp (
    .clk     (clk),
    .rst     (rst),
    .asyncIn (async_in),
    .startWr (start_wr),
    .pol     (pol),
    .strobes (strobes)
  );

  adc_trig_fsm u_fsm (
    .clk       (clk),
    .rst       (rst),
    .strobes   (strobes),
    .srcSel    (src_sel),
    .autoMode  (auto_mode),
    .convDone  (conv_done),
    .convStart (conv_start),
    .busy      (busy),
    .primed    (primed)
  );

endmodule

// File: rtl/adc_trig_chk.sv
module adc_trig_chk (
  input logic clk,
  input logic rst,
  input logic async_in,
  input logic start_wr,
  input logic src_sel,
  input logic pol,
  input logic auto_mode,
  input logic conv_done,
  input logic conv_start,
  input logic busy,
  input logic primed
);

  logic unusedIn;
  assign unusedIn = async_in ^ start_wr ^ pol;

  a_r1_start_one_cycle: assert property (@(posedge clk) disable iff (rst)
    conv_start |=> !conv_start);

  a_r1_start_with_busy: assert property (@(posedge clk) disable iff (rst)
    conv_start |-> busy);

  a_r2_busy_holds: assert property (@(posedge clk) disable iff (rst)
    busy && !conv_done |=> busy);

  a_r2_done_clears: assert property (@(posedge clk) disable iff (rst)
    busy && conv_done |=> !busy);

  a_r3_locked_while_busy: assert property (@(posedge clk) disable iff (rst)
    busy |=> !conv_start);

  a_r7_edge_needs_prime: assert property (@(posedge clk) disable iff (rst)
    conv_start && $past(src_sel) && !$past(auto_mode) |-> $past(primed));

  a_r8_no_prime_while_busy: assert property (@(posedge clk) disable iff (rst)
    busy && !primed |=> !primed);

  a_r10_primed_only_in_mode: assert property (@(posedge clk) disable iff (rst)
    !(src_sel && !auto_mode) |=> !primed);

endmodule

bind adc_trig_ctrl adc_trig_chk u_chk (.*);

// File: tb/adc_trig_ctrl_tb_top.sv
module adc_trig_ctrl_tb_top;

  localparam int SYNC = 2;
  localparam int FILT = 3;
  localparam int EXT_LAT = SYNC + FILT + 1;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic async_in = 1'b0;
  logic start_wr = 1'b0;
  logic src_sel = 1'b0;
  logic pol = 1'b0;
  logic auto_mode = 1'b1;
  logic conv_done = 1'b0;
  logic conv_start;
  logic busy;
  logic primed;

  int cyc = 0;
  int compared = 0;
  int mismatched = 0;
  string curReq = "R9";

  typedef struct {
    int    cyc;
    string req;
  } expItem_t;

  expItem_t expQ[$];

  adc_trig_ctrl #(.SYNC_STAGES(SYNC), .FILT_CYCLES(FILT)) dut_i (
    .clk(clk), .rst(rst), .async_in(async_in), .start_wr(start_wr),
    .src_sel(src_sel), .pol(pol), .auto_mode(auto_mode),
    .conv_done(conv_done), .conv_start(conv_start), .busy(busy),
    .primed(primed)
  );

  always #10 clk = ~clk;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic fail(string req, string what, int act, int exp);
    mismatched++;
    $display("FAIL %s %s: actual=%0d expected=%0d (cycle %0d)", req, what, act, exp, cyc);
  endtask

  task automatic check(string req, string what, logic act, logic exp);
    compared++;
    if (act !== exp) fail(req, what, int'(act), int'(exp));
  endtask

  // Monitor: every conv_start must match the head of the expectation queue
  always @(negedge clk) begin
    if (!rst && conv_start === 1'b1) begin
      compared++;
      if (expQ.size() == 0) begin
        fail(curReq, "unexpected conv_start", cyc, -1);
      end else begin
        expItem_t e;
        e = expQ.pop_front();
        if (e.cyc != cyc) fail(e.req, "conv_start cycle", cyc, e.cyc);
      end
    end
  end

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic expectStart(int delay, string req);
    expItem_t e;
    e.cyc = cyc + delay;
    e.req = req;
    expQ.push_back(e);
  endtask

  task automatic drained(string req);
    compared++;
    if (expQ.size() != 0) begin
      fail(req, "missing conv_start", 0, expQ.size());
      expQ.delete();
    end
  endtask

  task automatic swWrite();
    start_wr = 1'b1;
    tick(1);
    start_wr = 1'b0;
  endtask

  task automatic doneP();
    conv_done = 1'b1;
    tick(1);
    conv_done = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fail("R0", "watchdog expired", 0, 1);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    // R9: reset state and edge-free release
    tick(3);
    check("R9", "conv_start in reset", conv_start, 1'b0);
    check("R9", "busy in reset", busy, 1'b0);
    check("R9", "primed in reset", primed, 1'b0);
    rst = 1'b0;
    src_sel = 1'b1;
    tick(10);
    check("R9", "busy after release", busy, 1'b0);

    // R1: software start
    src_sel = 1'b0; curReq = "R1";
    expectStart(1, "R1");
    swWrite();
    check("R1", "busy with start", busy, 1'b1);
    tick(4);
    check("R2", "busy held", busy, 1'b1);
    doneP();
    check("R2", "busy cleared by done", busy, 1'b0);
    drained("R1");

    // R3: lockout, including request coincident with done
    curReq = "R3";
    expectStart(1, "R3");
    swWrite();
    tick(1);
    swWrite();
    conv_done = 1'b1; start_wr = 1'b1;
    tick(1);
    conv_done = 1'b0; start_wr = 1'b0;
    check("R3", "busy after done", busy, 1'b0);
    tick(3);
    drained("R3");

    // R2: done while idle has no effect
    curReq = "R2";
    doneP();
    check("R2", "busy after idle done", busy, 1'b0);
    expectStart(1, "R2");
    swWrite();
    check("R2", "busy after restart", busy, 1'b1);
    doneP();
    drained("R2");

    // R4 / R5: external source, automatic, rising edge
    src_sel = 1'b1; auto_mode = 1'b1; pol = 1'b0; curReq = "R4";
    tick(2);
    expectStart(EXT_LAT, "R5");
    async_in = 1'b1;
    tick(EXT_LAT + 2);
    doneP();
    async_in = 1'b0;       // falling edge: not qualified with pol=0
    tick(10);
    drained("R4");
    pol = 1'b1;
    tick(2);
    async_in = 1'b1;       // rising edge: not qualified with pol=1
    tick(10);
    check("R4", "busy after wrong edge", busy, 1'b0);
    expectStart(EXT_LAT, "R4");
    async_in = 1'b0;
    tick(EXT_LAT + 2);
    doneP();
    drained("R4");

    // R5: glitch one cycle short is dropped, minimum width accepted
    pol = 1'b0; curReq = "R5";
    tick(6);
    async_in = 1'b1;
    tick(FILT - 1);
    async_in = 1'b0;
    tick(10);
    check("R5", "busy after glitch", busy, 1'b0);
    expectStart(EXT_LAT, "R5");
    async_in = 1'b1;
    tick(FILT);
    async_in = 1'b0;
    tick(8);
    doneP();
    tick(6);
    drained("R5");

    // R6: automatic mode ignores start_wr, every edge starts
    curReq = "R6";
    swWrite();
    tick(1);
    check("R6", "primed after write", primed, 1'b0);
    tick(4);
    for (int i = 0; i < 2; i++) begin
      expectStart(EXT_LAT, "R6");
      async_in = 1'b1;
      tick(EXT_LAT + 1);
      doneP();
      async_in = 1'b0;
      tick(8);
    end
    drained("R6");

    // R7: primed style
    auto_mode = 1'b0; curReq = "R7";
    tick(2);
    async_in = 1'b1;
    tick(10);
    async_in = 1'b0;
    tick(10);
    check("R7", "primed before write", primed, 1'b0);
    swWrite();
    check("R7", "primed after write", primed, 1'b1);
    check("R7", "no start from write", busy, 1'b0);
    tick(3);
    expectStart(EXT_LAT, "R7");
    async_in = 1'b1;
    tick(EXT_LAT + 1);
    doneP();
    check("R7", "primed after done", primed, 1'b0);
    async_in = 1'b0;
    tick(10);
    async_in = 1'b1;
    tick(10);
    check("R7", "busy without re-prime", busy, 1'b0);
    async_in = 1'b0;
    tick(8);
    drained("R7");

    // R8: write while busy does not pre-arm
    curReq = "R8";
    swWrite();
    expectStart(EXT_LAT, "R8");
    async_in = 1'b1;
    tick(EXT_LAT + 1);
    swWrite();
    doneP();
    tick(1);
    check("R8", "primed after busy write", primed, 1'b0);
    async_in = 1'b0;
    tick(8);
    async_in = 1'b1;
    tick(10);
    check("R8", "busy after unarmed edge", busy, 1'b0);
    async_in = 1'b0;
    tick(8);
    drained("R8");

    // R10: leaving primed style drops primed
    curReq = "R10";
    swWrite();
    check("R10", "primed armed", primed, 1'b1);
    auto_mode = 1'b1;
    tick(1);
    check("R10", "primed in auto", primed, 1'b0);
    auto_mode = 1'b0;
    swWrite();
    src_sel = 1'b0;
    tick(1);
    check("R10", "primed in software source", primed, 1'b0);
    tick(2);

    // R9: reset with falling-edge polarity and pin idling high
    curReq = "R9";
    src_sel = 1'b1; auto_mode = 1'b1; pol = 1'b1; async_in = 1'b1;
    rst = 1'b1;
    tick(3);
    rst = 1'b0;
    tick(12);
    check("R9", "busy after high-idle release", busy, 1'b0);
    drained("R9");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule